// File: doc/BRIEF.md
# Isochronous Endpoint Retirement Controller

This block follows one isochronous endpoint from the moment a transfer descriptor is armed until that descriptor is retired. A load strobe arms it with four values: the per-frame packet multiplier from the queue head, an optional override, the largest packet the endpoint accepts and the byte allocation of the descriptor. From then on the block watches per-packet events and the (micro)frame boundary pulse.

It retires the descriptor when the expected number of packets has been seen. It also retires on a frame that ended part-way through its packets, on a receive packet that closes the burst early, on a receive packet that overflows, and on a receive CRC failure. Each retirement produces a one-cycle retire pulse and raises a request for the next descriptor. Transaction-error and buffer-error flags record why the descriptor ended. Partial frames are never retried, and an endpoint that sees no traffic stays armed with no time limit.

Top module: `iso_retire_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all outputs are low, the byte count is zero and the endpoint is not armed.
- R2: For a transmit descriptor the packet multiplier is the override field when that field is nonzero, otherwise the queue-head multiplier. A receive descriptor always uses the queue-head multiplier. A multiplier of zero counts as one.
- R3: The packet that brings the multiplier count to zero retires the descriptor. `retire` is high for exactly the one cycle after that packet.
- R4: When a frame boundary arrives after at least one packet but fewer than the multiplier in that frame, `xact_err` is set and the descriptor retires in the same cycle. Packet and multiplier counts restart at every frame boundary.
- R5: Frame boundaries with no packet in the frame leave the descriptor armed, with no retirement and no error, for any number of frames.
- R6: A receive packet whose data PID is not MDATA retires the descriptor. PID encoding on `pkt_pid` is 00 DATA0, 01 DATA1, 10 DATA2, 11 MDATA.
- R7: A receive packet longer than the maximum packet length, or longer than the remaining byte count, sets `buf_err`, retires the descriptor and leaves the byte count unchanged. A length equal to either limit is accepted.
- R8: A receive packet with a CRC failure sets `xact_err` and retires the descriptor. Its length is still subtracted from the byte count.
- R9: `prime_req` rises with `retire` and stays high until the next load. Packet and frame events while the endpoint is not armed change no output.
- R10: Each accepted packet lowers `bytes_left` by its length, and a transmit packet stops the count at zero. A packet whose direction differs from the armed descriptor's direction is ignored.
- R11: `xact_err` and `buf_err` hold their value until the next load, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dsc_load | input | 1 | Arms a new descriptor with the fields below |
| dsc_is_rx | input | 1 | Descriptor direction, 1 = receive |
| dsc_qh_mult | input | MULT_W | Queue-head packet multiplier |
| dsc_mult_ovr | input | MULT_W | Descriptor multiplier override, 0 = none |
| dsc_max_len | input | LEN_W | Maximum packet length in bytes |
| dsc_total | input | BYTES_W | Byte allocation of the descriptor |
| pkt_valid | input | 1 | One completed packet this cycle |
| pkt_is_rx | input | 1 | Packet direction, 1 = receive |
| pkt_pid | input | 2 | Data PID of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_crc_err | input | 1 | Receive packet failed its CRC |
| frame_tick | input | 1 | (Micro)frame boundary pulse |
| retire | output | 1 | One-cycle descriptor retirement pulse |
| xact_err | output | 1 | Sticky transaction-error flag |
| buf_err | output | 1 | Sticky buffer-error flag |
| bytes_left | output | BYTES_W | Remaining byte allocation |
| prime_req | output | 1 | Request to arm the next descriptor |

## Verification
The bench targets the frame boundary after a short burst. A design that forgets the fulfillment rule would leave the descriptor armed, and one that counts empty frames as short would retire idle endpoints. Receive lengths exactly at the packet limit and at the remaining allocation are driven next to lengths one byte over; an off-by-one compare shows up as a wrong `buf_err`. It also drives transmit overrides against receive descriptors, a zero multiplier, and CRC failures that must still consume bytes. A randomized phase places packets, loads and frame pulses in the same cycle, where a wrong priority gives a spurious `xact_err` or a missed retirement.

// File: rtl/iso_rc_pkg.sv
package iso_rc_pkg;
  // Two-bit data PID code carried with every packet event
  typedef enum logic [1:0] {
    PID_DATA0 = 2'b00,
    PID_DATA1 = 2'b01,
    PID_DATA2 = 2'b10,
    PID_MDATA = 2'b11
  } pid_e;
endpackage

// File: rtl/iso_rc_mult.sv
// Per-frame multiplier countdown and packets-seen counter
module iso_rc_mult #(
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_is_rx,
  input  logic [MULT_W-1:0] qh_mult,
  input  logic [MULT_W-1:0] ovr_mult,
  input  logic              accept,
  input  logic              frame,
  input  logic              clear,
  output logic              mult_done,
  output logic              short_frame
);
  // Effective multiplier: override for transmit if nonzero, zero becomes one
  function automatic logic [MULT_W-1:0] eff_mult(input logic is_rx,
                                                  input logic [MULT_W-1:0] qh,
                                                  input logic [MULT_W-1:0] ov);
    logic [MULT_W-1:0] m;
    m = (!is_rx && ov != '0) ? ov : qh;
    if (m == '0) m = MULT_W'(1);
    return m;
  endfunction

  logic [MULT_W-1:0] cfg_q, cnt_q, seen_q;

  assign mult_done   = accept && (cnt_q == MULT_W'(1));
  assign short_frame = frame && !mult_done && ((seen_q != '0) || accept);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= MULT_W'(1);
      cnt_q  <= MULT_W'(1);
      seen_q <= '0;
    end else if (load) begin
      cfg_q  <= eff_mult(load_is_rx, qh_mult, ovr_mult);
      cnt_q  <= eff_mult(load_is_rx, qh_mult, ovr_mult);
      seen_q <= '0;
    end else if (clear || frame) begin
      cnt_q  <= cfg_q;
      seen_q <= '0;
    end else if (accept) begin
      cnt_q  <= cnt_q - MULT_W'(1);
      seen_q <= seen_q + MULT_W'(1);
    end
  end

  // R3: the countdown never sits at zero nor above its configured start
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) && (cnt_q <= cfg_q));
  // R4: packets seen in a frame stay below the multiplier
  a_r4_seen_below_mult: assert property (@(posedge clk) disable iff (rst)
    seen_q < cfg_q);
endmodule

// File: rtl/iso_rc_bytes.sv
// Remaining byte allocation and receive overflow detection
module iso_rc_bytes #(
  parameter int LEN_W   = 11,
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [BYTES_W-1:0] total,
  input  logic [LEN_W-1:0]   max_len,
  input  logic               accept,
  input  logic               is_rx,
  input  logic [LEN_W-1:0]   len,
  output logic [BYTES_W-1:0] left,
  output logic               ovf
);
  logic [LEN_W-1:0]   max_q;
  logic [BYTES_W-1:0] left_q;

  function automatic logic too_big(input logic [LEN_W-1:0] l,
                                   input logic [LEN_W-1:0] lim,
                                   input logic [BYTES_W-1:0] room);
    return (l > lim) || (BYTES_W'(l) > room);
  endfunction

  function automatic logic [BYTES_W-1:0] sub_floor(input logic [BYTES_W-1:0] room,
                                                   input logic [LEN_W-1:0] l);
    return (BYTES_W'(l) >= room) ? '0 : room - BYTES_W'(l);
  endfunction

  assign ovf  = accept && is_rx && too_big(len, max_q, left_q);
  assign left = left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      max_q  <= max_len;
      left_q <= total;
    end else if (accept && !ovf) begin
      left_q <= sub_floor(left_q, len);
    end
  end

  // R10: without a load the allocation never grows
  a_r10_no_growth: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> (left_q <= $past(left_q)));
  // R7: an overflowing packet leaves the count untouched
  a_r7_ovf_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (ovf && !load) |=> $stable(left_q));
endmodule

// File: rtl/iso_retire_ctrl.sv
module iso_retire_ctrl #(
  parameter int MULT_W  = 2,
  parameter int LEN_W   = 11,
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dsc_load,
  input  logic               dsc_is_rx,
  input  logic [MULT_W-1:0]  dsc_qh_mult,
  input  logic [MULT_W-1:0]  dsc_mult_ovr,
  input  logic [LEN_W-1:0]   dsc_max_len,
  input  logic [BYTES_W-1:0] dsc_total,
  input  logic               pkt_valid,
  input  logic               pkt_is_rx,
  input  logic [1:0]         pkt_pid,
  input  logic [LEN_W-1:0]   pkt_len,
  input  logic               pkt_crc_err,
  input  logic               frame_tick,
  output logic               retire,
  output logic               xact_err,
  output logic               buf_err,
  output logic [BYTES_W-1:0] bytes_left,
  output logic               prime_req
);
  import iso_rc_pkg::*;

  logic active_q, rx_q, retire_q, xerr_q, berr_q, prime_q;

  // Named internal events
  logic live, accept, frame_live, ovf, mult_done, short_frame;
  logic rx_stop, crc_hit, fulfil_fail, retire_now;

  assign live        = active_q && !dsc_load;
  assign accept      = live && pkt_valid && (pkt_is_rx == rx_q);
  assign frame_live  = live && frame_tick;
  assign crc_hit     = accept && rx_q && pkt_crc_err;
  assign rx_stop     = accept && rx_q && (ovf || pkt_crc_err || (pid_e'(pkt_pid) != PID_MDATA));
  assign fulfil_fail = short_frame && !rx_stop;
  assign retire_now  = mult_done || rx_stop || fulfil_fail;

  iso_rc_mult #(.MULT_W(MULT_W)) u_mult (
    .clk        (clk),
    .rst        (rst),
    .load       (dsc_load),
    .load_is_rx (dsc_is_rx),
    .qh_mult    (dsc_qh_mult),
    .ovr_mult   (dsc_mult_ovr),
    .accept     (accept),
    .frame      (frame_live),
    .clear      (retire_now),
    .mult_done  (mult_done),
    .short_frame(short_frame)
  );

  iso_rc_bytes #(.LEN_W(LEN_W), .BYTES_W(BYTES_W)) u_bytes (
    .clk    (clk),
    .rst    (rst),
    .load   (dsc_load),
    .total  (dsc_total),
    .max_len(dsc_max_len),
    .accept (accept),
    .is_rx  (rx_q),
    .len    (pkt_len),
    .left   (bytes_left),
    .ovf    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rx_q     <= 1'b0;
      retire_q <= 1'b0;
      xerr_q   <= 1'b0;
      berr_q   <= 1'b0;
      prime_q  <= 1'b0;
    end else begin
      retire_q <= retire_now;
      if (dsc_load) begin
        active_q <= 1'b1;
        rx_q     <= dsc_is_rx;
        xerr_q   <= 1'b0;
        berr_q   <= 1'b0;
        prime_q  <= 1'b0;
      end else begin
        if (retire_now) begin
          active_q <= 1'b0;
          prime_q  <= 1'b1;
        end
        xerr_q <= xerr_q | crc_hit | fulfil_fail;
        berr_q <= berr_q | ovf;
      end
    end
  end

  assign retire   = retire_q;
  assign xact_err = xerr_q;
  assign buf_err  = berr_q;
  assign prime_req = prime_q;

  // R3: retirement is a single-cycle pulse
  a_r3_retire_single: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire);
  // R9: every retirement comes with a prime request
  a_r9_prime_with_retire: assert property (@(posedge clk) disable iff (rst)
    retire |-> prime_req);
  // R9: nothing retires while the endpoint is not armed
  a_r9_no_retire_unarmed: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !dsc_load) |=> !retire);
  // R4: a short frame flags a transaction error and retires
  a_r4_short_frame: assert property (@(posedge clk) disable iff (rst)
    fulfil_fail |=> (xact_err && retire));
  // R11: flags are clear right after a load and sticky otherwise
  a_r11_clear_on_load: assert property (@(posedge clk) disable iff (rst)
    dsc_load |=> (!xact_err && !buf_err));
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (xact_err && !dsc_load) |=> xact_err);
endmodule

// File: tb/sim_iso_retire_ctrl.sv
`timescale 1ns/1ps
module sim_iso_retire_ctrl;
  localparam int MW = 2;
  localparam int LW = 11;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dsc_load = 0, dsc_is_rx = 0;
  logic [MW-1:0] dsc_qh_mult = 0, dsc_mult_ovr = 0;
  logic [LW-1:0] dsc_max_len = 0;
  logic [BW-1:0] dsc_total = 0;
  logic pkt_valid = 0, pkt_is_rx = 0, pkt_crc_err = 0, frame_tick = 0;
  logic [1:0] pkt_pid = 0;
  logic [LW-1:0] pkt_len = 0;
  logic retire, xact_err, buf_err, prime_req;
  logic [BW-1:0] bytes_left;

  always #2.5 clk = ~clk;

  iso_retire_ctrl #(.MULT_W(MW), .LEN_W(LW), .BYTES_W(BW)) u0 (
    .clk(clk), .rst(rst), .dsc_load(dsc_load), .dsc_is_rx(dsc_is_rx),
    .dsc_qh_mult(dsc_qh_mult), .dsc_mult_ovr(dsc_mult_ovr),
    .dsc_max_len(dsc_max_len), .dsc_total(dsc_total),
    .pkt_valid(pkt_valid), .pkt_is_rx(pkt_is_rx), .pkt_pid(pkt_pid),
    .pkt_len(pkt_len), .pkt_crc_err(pkt_crc_err), .frame_tick(frame_tick),
    .retire(retire), .xact_err(xact_err), .buf_err(buf_err),
    .bytes_left(bytes_left), .prime_req(prime_req)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Behavioural reference: counts packets seen rather than counting down
  int m_active, m_rx, m_mult, m_seen, m_max, m_bytes, m_xe, m_be, m_ret, m_prime;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int stop;
    if (rst) begin
      m_active = 0; m_rx = 0; m_mult = 1; m_seen = 0; m_max = 0;
      m_bytes = 0; m_xe = 0; m_be = 0; m_ret = 0; m_prime = 0;
      return;
    end
    m_ret = 0;
    if (dsc_load) begin
      m_active = 1; m_rx = dsc_is_rx; m_seen = 0;
      m_mult = (!dsc_is_rx && dsc_mult_ovr != 0) ? int'(dsc_mult_ovr) : int'(dsc_qh_mult);
      if (m_mult == 0) m_mult = 1;
      m_max = dsc_max_len; m_bytes = dsc_total;
      m_xe = 0; m_be = 0; m_prime = 0;
      return;
    end
    if (m_active == 0) return;
    stop = 0;
    if (pkt_valid && int'(pkt_is_rx) == m_rx) begin
      m_seen++;
      if (m_rx != 0) begin
        if (pkt_len > m_max || pkt_len > m_bytes) begin m_be = 1; stop = 1; end
        else m_bytes -= pkt_len;
        if (pkt_crc_err) begin m_xe = 1; stop = 1; end
        if (pkt_pid != 2'b11) stop = 1;
      end else begin
        m_bytes = (pkt_len >= m_bytes) ? 0 : m_bytes - pkt_len;
      end
      if (m_seen == m_mult) stop = 1;
    end
    if (stop == 0 && frame_tick && m_seen > 0) begin m_xe = 1; stop = 1; end
    if (stop != 0) begin
      m_active = 0; m_ret = 1; m_prime = 1; m_seen = 0;
    end else if (frame_tick) begin
      m_seen = 0;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    chk(cur_req, retire, m_ret, "retire");
    chk(cur_req, xact_err, m_xe, "xact_err");
    chk(cur_req, buf_err, m_be, "buf_err");
    chk(cur_req, bytes_left, m_bytes, "bytes_left");
    chk(cur_req, prime_req, m_prime, "prime_req");
  endtask

  task automatic load(input bit rx, input int qh, input int ov, input int mx, input int tot);
    dsc_load = 1; dsc_is_rx = rx; dsc_qh_mult = MW'(qh); dsc_mult_ovr = MW'(ov);
    dsc_max_len = LW'(mx); dsc_total = BW'(tot);
    cyc();
    dsc_load = 0;
  endtask

  task automatic pkt(input bit rx, input int pid, input int len, input bit crc);
    pkt_valid = 1; pkt_is_rx = rx; pkt_pid = 2'(pid); pkt_len = LW'(len); pkt_crc_err = crc;
    cyc();
    pkt_valid = 0; pkt_crc_err = 0;
  endtask

  task automatic frame();
    frame_tick = 1;
    cyc();
    frame_tick = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (4) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1", retire, 0, "retire"); chk("R1", prime_req, 0, "prime_req");
    chk("R1", xact_err, 0, "xact_err"); chk("R1", bytes_left, 0, "bytes_left");

    // R3 count to zero with no override, R10 byte accounting
    cur_req = "R3";
    load(0, 3, 0, 512, 3000);
    pkt(0, 0, 100, 0); pkt(0, 0, 100, 0);
    chk("R3", retire, 0, "retire before last");
    pkt(0, 0, 100, 0);
    chk("R3", retire, 1, "retire on third");
    chk("R10", bytes_left, 2700, "bytes after three");
    cyc();
    chk("R3", retire, 0, "pulse width");
    chk("R9", prime_req, 1, "prime held");

    // R2 transmit override takes precedence
    cur_req = "R2";
    load(0, 3, 1, 512, 1000);
    pkt(0, 0, 10, 0);
    chk("R2", retire, 1, "override 1 retires");
    chk("R2", xact_err, 0, "no error");
    load(0, 1, 2, 512, 1000);
    pkt(0, 0, 10, 0);
    chk("R2", retire, 0, "override 2 first");
    pkt(0, 0, 10, 0);
    chk("R2", retire, 1, "override 2 second");
    // receive ignores override
    load(1, 2, 1, 200, 1000);
    pkt(1, 3, 50, 0);
    chk("R2", retire, 0, "rx ignores override");
    pkt(1, 3, 50, 0);
    chk("R2", retire, 1, "rx mult 2 done");
    // zero multiplier counts as one
    load(0, 0, 0, 100, 100);
    pkt(0, 0, 5, 0);
    chk("R2", retire, 1, "zero mult as one");

    // R4 short frame
    cur_req = "R4";
    load(0, 3, 0, 512, 2000);
    pkt(0, 0, 20, 0); pkt(0, 0, 20, 0);
    frame();
    chk("R4", retire, 1, "short frame retires");
    chk("R4", xact_err, 1, "short frame error");

    // R5 idle frames
    cur_req = "R5";
    load(0, 2, 0, 512, 2000);
    for (int i = 0; i < 5; i++) begin
      frame(); cyc();
      chk("R5", retire, 0, "idle retire");
      chk("R5", xact_err, 0, "idle error");
    end
    pkt(0, 0, 30, 0); pkt(0, 0, 30, 0);
    chk("R5", retire, 1, "full burst after idle");
    chk("R5", xact_err, 0, "no error after idle");

    // R6 non-MDATA PID
    cur_req = "R6";
    load(1, 3, 0, 300, 2000);
    pkt(1, 0, 100, 0);
    chk("R6", retire, 1, "DATA0 retires");
    chk("R6", bytes_left, 1900, "bytes stored");

    // R7 overflows and exact limits
    cur_req = "R7";
    load(1, 3, 0, 100, 1000);
    pkt(1, 3, 100, 0);
    chk("R7", buf_err, 0, "len equal max ok");
    pkt(1, 3, 101, 0);
    chk("R7", buf_err, 1, "len over max");
    chk("R7", retire, 1, "over max retires");
    chk("R7", bytes_left, 900, "bytes unchanged");
    load(1, 3, 0, 500, 120);
    pkt(1, 3, 120, 0);
    chk("R7", buf_err, 0, "len equal room ok");
    chk("R7", bytes_left, 0, "room used up");
    pkt(1, 3, 1, 0);
    chk("R7", buf_err, 1, "over room");
    chk("R7", retire, 1, "over room retires");

    // R8 CRC failure
    cur_req = "R8";
    load(1, 3, 0, 500, 1000);
    pkt(1, 3, 80, 1);
    chk("R8", xact_err, 1, "crc error");
    chk("R8", retire, 1, "crc retires");
    chk("R8", bytes_left, 920, "crc data counted");
    chk("R8", buf_err, 0, "no buffer error");

    // R11 sticky then cleared, R9 idle when unarmed
    cur_req = "R11";
    repeat (3) cyc();
    chk("R11", xact_err, 1, "sticky");
    cur_req = "R9";
    pkt(1, 3, 40, 0); pkt(0, 0, 40, 0); frame();
    chk("R9", retire, 0, "unarmed no retire");
    chk("R9", bytes_left, 920, "unarmed bytes");
    chk("R9", prime_req, 1, "prime until load");
    cur_req = "R11";
    load(0, 2, 0, 500, 500);
    chk("R11", xact_err, 0, "cleared by load");
    chk("R9", prime_req, 0, "prime cleared by load");

    // R10 wrong direction ignored, transmit floor at zero
    cur_req = "R10";
    pkt(1, 3, 40, 0);
    chk("R10", bytes_left, 500, "wrong direction ignored");
    chk("R10", retire, 0, "wrong direction no retire");
    pkt(0, 0, 40, 0);
    chk("R10", bytes_left, 460, "tx decrement");
    load(0, 1, 0, 500, 30);
    pkt(0, 0, 50, 0);
    chk("R10", bytes_left, 0, "tx floor");

    // Random traffic against the model
    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      dsc_load = ($urandom % 25) == 0;
      dsc_is_rx = $urandom % 2; dsc_qh_mult = MW'($urandom % 4);
      dsc_mult_ovr = MW'($urandom % 4); dsc_max_len = LW'($urandom % 700);
      dsc_total = BW'($urandom % 3000);
      pkt_valid = ($urandom % 3) == 0; pkt_is_rx = $urandom % 2;
      pkt_pid = 2'($urandom % 4); pkt_len = LW'($urandom % 600);
      pkt_crc_err = ($urandom % 10) == 0; frame_tick = ($urandom % 6) == 0;
      cyc();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule